// File: doc/BRIEF.md
# Power-Manager Command Executor with Calendar Counter

This block executes one power-management command at a time. A dispatcher upstream hands it a command code, the number of argument bytes received, up to four argument bytes, and the response length that its command table expects. The block checks the argument count for the command and carries out the action. It then returns a response of up to `RSP_MAX` bytes together with a byte count and an error flag.

A calendar counter inside the block keeps time in seconds from the start of 1904. Its value is the sum of a free-running seconds counter and an offset. The seconds counter advances on a once-per-second `sec_tick` pulse. Writing the clock rewrites only the offset. Shutdown and reboot requests leave the block as single-cycle pulses toward the system controller.

Commands enter on a valid/ready stream and responses leave on a second one. The block holds one response at a time. `cmd_ready` is high only while no response is waiting. A response stays on `rsp_*`, unchanged, until a cycle in which `rsp_ready` is high. A source may hold `cmd_valid` high for as long as it likes, and a sink may stall for as long as it likes.

Top module: `pmgr_cmd_exec`

## Requirements
- R1: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. Its response appears with `rsp_valid` high on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data`, `rsp_size` and `rsp_err` hold their values. `cmd_ready` stays low until the response has been taken.
- R2: After reset the calendar reads 2082844800, which is the first second of 1970 counted from 1904. It gains exactly one per `sec_tick` cycle. Get-clock (code 0x38) with zero argument bytes returns 4 bytes, most significant first. Response byte i is `rsp_data[8*i +: 8]`.
- R3: Set-clock (code 0x30) with exactly 4 argument bytes loads the calendar from them. Argument byte i is `cmd_args[8*i +: 8]`, and byte 0 is the most significant. A later get-clock returns the written value plus the number of ticks since the write. The response is empty.
- R4: Shutdown (code 0x7E) with 4 argument bytes always returns one byte of 0x00. It pulses `shutdown_req` for one cycle, in the first cycle of that response, only when argument bytes 0 to 3 are 0x4D, 0x41, 0x54, 0x54.
- R5: Reboot (code 0xD0) with zero argument bytes returns an empty response and pulses `reset_req` for one cycle, in the first cycle of that response.
- R6: The fixed queries take any argument count and each returns one byte. Version (0xEA) returns 0x01, download status (0xE2) returns 0x62 and lid status (0xDC) returns 0x00. System-ready (0xDF) returns an empty response.
- R7: Power events (0x8F) needs at least one argument byte, and argument byte 0 selects the subcommand. Subcommands 0 and 3 return two 0x00 bytes. Subcommands 1, 2, 4 and 5 return an empty response. Any other subcommand returns size 0 with `rsp_err` high.
- R8: Any other code returns all-zero bytes with `rsp_err` low. The size is 0 when `cmd_rsp_var` is high. Otherwise the size is `cmd_rsp_len`, limited to `RSP_MAX`.
- R9: A wrong argument count raises `rsp_err` and returns size 0. The wrong counts are: get-clock or reboot not 0, set-clock or shutdown not 4, power events 0. Such a command pulses nothing and leaves the calendar unchanged.
- R10: Every response byte at or above `rsp_size` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_code | input | 8 | Command code |
| cmd_len | input | 8 | Number of argument bytes received |
| cmd_args | input | 8*ARG_MAX | Argument bytes, byte i at [8*i +: 8] |
| cmd_rsp_var | input | 1 | Table marks the response length as variable |
| cmd_rsp_len | input | 8 | Response length the table expects |
| rsp_valid | output | 1 | Response waiting |
| rsp_ready | input | 1 | Sink takes the response |
| rsp_data | output | 8*RSP_MAX | Response bytes, byte i at [8*i +: 8] |
| rsp_size | output | $clog2(RSP_MAX+1) | Response byte count |
| rsp_err | output | 1 | Argument count or subcommand rejected |
| shutdown_req | output | 1 | Power-off request pulse |
| reset_req | output | 1 | Reboot request pulse |

## Verification
The bench aims at the calendar after a write. A design that subtracted the pre-tick seconds value would read one second high when a tick lands next to the write. A design that computed the offset without subtracting the counter would drift by the time that had already elapsed.

Shutdown is driven with the correct signature, with a signature that differs in its last byte, and with a three-byte argument list. A design that compared only part of the signature would power off falsely. A design that let a bad argument count reach the action would pulse when it should not.

Unknown codes are sent with expected lengths above `RSP_MAX` and with the variable-length flag. A design without the limit would report sizes it cannot hold. Long random stalls on `rsp_ready` show any response that changes, or any pulse that repeats, while the sink holds off.

// File: rtl/pmgr_pkg.sv
package pmgr_pkg;
  localparam logic [7:0] OP_GET_CLK  = 8'h38;
  localparam logic [7:0] OP_SET_CLK  = 8'h30;
  localparam logic [7:0] OP_SHUTDOWN = 8'h7E;
  localparam logic [7:0] OP_REBOOT   = 8'hD0;
  localparam logic [7:0] OP_VERSION  = 8'hEA;
  localparam logic [7:0] OP_DL_STAT  = 8'hE2;
  localparam logic [7:0] OP_LID      = 8'hDC;
  localparam logic [7:0] OP_READY    = 8'hDF;
  localparam logic [7:0] OP_PWR_EVT  = 8'h8F;

  localparam logic [31:0] OFF_SIGNATURE = 32'h4D41_5454;
  localparam logic [31:0] EPOCH_1970    = 32'd2082844800;

  localparam logic [7:0] VERSION_VAL = 8'h01;
  localparam logic [7:0] DL_STAT_VAL = 8'h62;
  localparam logic [7:0] LID_VAL     = 8'h00;
endpackage

// File: rtl/pmgr_calendar.sv
module pmgr_calendar #(
  parameter logic [31:0] START_TIME = 32'd2082844800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        load,
  input  logic [31:0] load_val,
  output logic [31:0] now
);
  logic [31:0] secs_q, secs_d, ofs_q;

  assign secs_d = secs_q + {31'd0, tick};
  assign now    = secs_q + ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secs_q <= '0;
      ofs_q  <= START_TIME;
    end else begin
      secs_q <= secs_d;
      if (load) ofs_q <= load_val - secs_d;
    end
  end

  assert_tick_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load |=> now == $past(now) + 32'd1);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load |=> $stable(now));
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> now == $past(load_val));
endmodule

// File: rtl/pmgr_decode.sv
module pmgr_decode
  import pmgr_pkg::*;
#(
  parameter int ARG_MAX = 4,
  parameter int RSP_MAX = 8,
  localparam int SW = $clog2(RSP_MAX + 1)
) (
  input  logic [7:0]           code,
  input  logic [7:0]           arg_cnt,
  input  logic [8*ARG_MAX-1:0] args,
  input  logic                 exp_var,
  input  logic [7:0]           exp_len,
  input  logic [31:0]          now,
  output logic [8*RSP_MAX-1:0] rsp,
  output logic [SW-1:0]        size,
  output logic                 err,
  output logic                 shut,
  output logic                 boot,
  output logic                 load,
  output logic [31:0]          load_val
);
  logic [31:0] arg_word;
  logic [7:0]  sub;
  logic [SW-1:0] exp_cap;

  assign arg_word = {args[7:0], args[15:8], args[23:16], args[31:24]};
  assign sub      = args[7:0];
  assign exp_cap  = (exp_len > 8'(RSP_MAX)) ? SW'(RSP_MAX) : exp_len[SW-1:0];
  assign load_val = arg_word;

  always_comb begin
    rsp  = '0;
    size = '0;
    err  = 1'b0;
    shut = 1'b0;
    boot = 1'b0;
    load = 1'b0;
    case (code)
      OP_GET_CLK: begin
        if (arg_cnt != 8'd0) err = 1'b1;
        else begin
          rsp[7:0]   = now[31:24];
          rsp[15:8]  = now[23:16];
          rsp[23:16] = now[15:8];
          rsp[31:24] = now[7:0];
          size = SW'(4);
        end
      end
      OP_SET_CLK: begin
        if (arg_cnt != 8'd4) err = 1'b1;
        else load = 1'b1;
      end
      OP_SHUTDOWN: begin
        if (arg_cnt != 8'd4) err = 1'b1;
        else begin
          size = SW'(1);
          shut = (arg_word == OFF_SIGNATURE);
        end
      end
      OP_REBOOT: begin
        if (arg_cnt != 8'd0) err = 1'b1;
        else boot = 1'b1;
      end
      OP_VERSION: begin
        rsp[7:0] = VERSION_VAL;
        size = SW'(1);
      end
      OP_DL_STAT: begin
        rsp[7:0] = DL_STAT_VAL;
        size = SW'(1);
      end
      OP_LID: begin
        rsp[7:0] = LID_VAL;
        size = SW'(1);
      end
      OP_READY: ;
      OP_PWR_EVT: begin
        if (arg_cnt == 8'd0) err = 1'b1;
        else begin
          case (sub)
            8'd0, 8'd3: size = SW'(2);
            8'd1, 8'd2, 8'd4, 8'd5: ;
            default: err = 1'b1;
          endcase
        end
      end
      default: begin
        if (!exp_var) size = exp_cap;
      end
    endcase
  end
endmodule

// File: rtl/pmgr_cmd_exec.sv
module pmgr_cmd_exec
  import pmgr_pkg::*;
#(
  parameter int ARG_MAX = 4,
  parameter int RSP_MAX = 8,
  parameter logic [31:0] START_TIME = EPOCH_1970,
  localparam int SW = $clog2(RSP_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_tick,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_code,
  input  logic [7:0]           cmd_len,
  input  logic [8*ARG_MAX-1:0] cmd_args,
  input  logic                 cmd_rsp_var,
  input  logic [7:0]           cmd_rsp_len,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [8*RSP_MAX-1:0] rsp_data,
  output logic [SW-1:0]        rsp_size,
  output logic                 rsp_err,
  output logic                 shutdown_req,
  output logic                 reset_req
);
  logic                 accept;
  logic [31:0]          now;
  logic [8*RSP_MAX-1:0] dec_rsp;
  logic [SW-1:0]        dec_size;
  logic                 dec_err, dec_shut, dec_boot, dec_load;
  logic [31:0]          dec_load_val;

  assign cmd_ready = !rsp_valid;
  assign accept    = cmd_valid && !rsp_valid;

  pmgr_calendar #(.START_TIME(START_TIME)) u_cal (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .load(accept && dec_load), .load_val(dec_load_val), .now(now)
  );

  pmgr_decode #(.ARG_MAX(ARG_MAX), .RSP_MAX(RSP_MAX)) u_dec (
    .code(cmd_code), .arg_cnt(cmd_len), .args(cmd_args),
    .exp_var(cmd_rsp_var), .exp_len(cmd_rsp_len), .now(now),
    .rsp(dec_rsp), .size(dec_size), .err(dec_err),
    .shut(dec_shut), .boot(dec_boot), .load(dec_load), .load_val(dec_load_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_size     <= '0;
      rsp_err      <= 1'b0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      shutdown_req <= accept && dec_shut;
      reset_req    <= accept && dec_boot;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= dec_rsp;
        rsp_size  <= dec_size;
        rsp_err   <= dec_err;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_size) && $stable(rsp_err));
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rsp_valid);
  assert_off_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> rsp_valid && rsp_size == SW'(1) && rsp_data[7:0] == 8'h00);
  assert_off_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  assert_boot_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> rsp_valid && rsp_size == '0 && !shutdown_req);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_size == '0 && !shutdown_req && !reset_req);
  assert_size_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_size <= SW'(RSP_MAX));
endmodule

// File: tb/pmgr_cmd_exec_test.sv
module pmgr_cmd_exec_test;
  localparam int ARG_MAX = 4;
  localparam int RSP_MAX = 8;
  localparam int SW = $clog2(RSP_MAX + 1);

  logic clk = 0, rst_n = 0, sec_tick = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [7:0] cmd_code = 0, cmd_len = 0, cmd_rsp_len = 0;
  logic [8*ARG_MAX-1:0] cmd_args = 0;
  logic cmd_rsp_var = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [8*RSP_MAX-1:0] rsp_data;
  logic [SW-1:0] rsp_size;
  logic rsp_err, shutdown_req, reset_req;

  int checks = 0, errors = 0;
  logic [31:0] model_time = 32'd2082844800;

  always #10 clk = ~clk;

  pmgr_cmd_exec uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_len(cmd_len), .cmd_args(cmd_args), .cmd_rsp_var(cmd_rsp_var),
    .cmd_rsp_len(cmd_rsp_len), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_size(rsp_size), .rsp_err(rsp_err),
    .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] c, input logic [7:0] l, input logic [31:0] a,
      input bit ev, input logic [7:0] el, input logic [31:0] t,
      output int sz, output logic [63:0] d, output bit er, output bit sd,
      output bit rb, output bit ld, output logic [31:0] lv);
    logic [31:0] w;
    w = {a[7:0], a[15:8], a[23:16], a[31:24]};
    sz = 0; d = 0; er = 0; sd = 0; rb = 0; ld = 0; lv = w;
    case (c)
      8'h38: if (l != 0) er = 1; else begin sz = 4; d[31:0] = {t[7:0], t[15:8], t[23:16], t[31:24]}; end
      8'h30: if (l != 4) er = 1; else ld = 1;
      8'h7E: if (l != 4) er = 1; else begin sz = 1; sd = (w == 32'h4D415454); end
      8'hD0: if (l != 0) er = 1; else rb = 1;
      8'hEA: begin sz = 1; d[7:0] = 8'h01; end
      8'hE2: begin sz = 1; d[7:0] = 8'h62; end
      8'hDC: sz = 1;
      8'hDF: ;
      8'h8F: if (l == 0) er = 1;
             else if (a[7:0] == 0 || a[7:0] == 3) sz = 2;
             else if (a[7:0] >= 1 && a[7:0] <= 5) sz = 0;
             else er = 1;
      default: if (!ev) sz = (el > RSP_MAX) ? RSP_MAX : int'(el);
    endcase
  endfunction

  task automatic tick_once();
    @(negedge clk) sec_tick = 1;
    @(negedge clk) sec_tick = 0;
    model_time = model_time + 1;
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic [7:0] l, input logic [31:0] a,
                        input bit ev, input logic [7:0] el, input int hold, input string tag);
    int sz; logic [63:0] d; bit er, sd, rb, ld; logic [31:0] lv;
    logic [63:0] held;
    model(c, l, a, ev, el, model_time, sz, d, er, sd, rb, ld, lv);
    @(negedge clk);
    check(cmd_ready == 1'b1, {tag, " R1 ready"}, cmd_ready, 1);
    cmd_valid = 1; cmd_code = c; cmd_len = l; cmd_args = a; cmd_rsp_var = ev; cmd_rsp_len = el;
    @(negedge clk);
    cmd_valid = 0;
    check(rsp_valid == 1'b1, {tag, " R1 valid"}, rsp_valid, 1);
    check(rsp_size == SW'(sz), {tag, " size"}, rsp_size, sz);
    check(rsp_data == d, {tag, " data R10"}, rsp_data, d);
    check(rsp_err == er, {tag, " err R9"}, rsp_err, er);
    check(shutdown_req == sd, {tag, " R4 shutdown"}, shutdown_req, sd);
    check(reset_req == rb, {tag, " R5 reboot"}, reset_req, rb);
    held = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == held && rsp_err == er, {tag, " R1 hold"}, rsp_data, held);
      check(!shutdown_req && !reset_req, {tag, " R4 single pulse"}, {shutdown_req, reset_req}, 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(!rsp_valid, {tag, " R1 drained"}, rsp_valid, 0);
    check(!shutdown_req && !reset_req, {tag, " R5 single pulse"}, {shutdown_req, reset_req}, 0);
    if (ld) model_time = lv;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] codes [9];
    void'($urandom(32'd1357));
    codes = '{8'h38, 8'h30, 8'h7E, 8'hD0, 8'hEA, 8'hE2, 8'hDC, 8'hDF, 8'h8F};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready && !rsp_valid && !shutdown_req && !reset_req, "reset state R1", {cmd_ready, rsp_valid}, 2'b10);
    do_cmd(8'h38, 0, 0, 0, 4, 0, "R2 clock after reset");
    repeat (3) tick_once();
    do_cmd(8'h38, 0, 0, 0, 4, 2, "R2 clock after ticks");
    do_cmd(8'h30, 4, 32'h78563412, 0, 0, 0, "R3 set clock");
    do_cmd(8'h38, 0, 0, 0, 4, 0, "R3 read back");
    repeat (2) tick_once();
    do_cmd(8'h38, 0, 0, 0, 4, 0, "R3 elapsed");
    do_cmd(8'h30, 3, 32'h00FFFFFF, 0, 0, 0, "R9 set short");
    do_cmd(8'h38, 0, 0, 0, 4, 0, "R9 clock unchanged");
    do_cmd(8'h38, 1, 0, 0, 4, 0, "R9 get with arg");
    do_cmd(8'h7E, 4, 32'h5454414D, 0, 1, 3, "R4 good signature");
    do_cmd(8'h7E, 4, 32'h5854414D, 0, 1, 0, "R4 bad signature");
    do_cmd(8'h7E, 3, 32'h5454414D, 0, 1, 0, "R9 shutdown short");
    do_cmd(8'hD0, 0, 0, 0, 0, 1, "R5 reboot");
    do_cmd(8'hD0, 1, 0, 0, 0, 0, "R9 reboot with arg");
    do_cmd(8'hEA, 2, 0, 0, 1, 0, "R6 version");
    do_cmd(8'hE2, 0, 0, 0, 1, 0, "R6 download status");
    do_cmd(8'hDC, 0, 0, 0, 1, 0, "R6 lid");
    do_cmd(8'hDF, 0, 0, 0, 0, 0, "R6 ready");
    for (int s = 0; s < 8; s++) do_cmd(8'h8F, 1, 32'(s), 0, 2, 0, "R7 power sub");
    do_cmd(8'h8F, 0, 0, 0, 2, 0, "R9 power empty");
    do_cmd(8'h55, 0, 0, 1, 6, 0, "R8 unknown variable");
    do_cmd(8'h55, 0, 0, 0, 3, 0, "R8 unknown fixed");
    do_cmd(8'h56, 0, 0, 0, 20, 0, "R8 unknown capped");
    for (int i = 0; i < 300; i++) begin
      logic [7:0] c;
      c = ($urandom % 2) ? codes[$urandom % 9] : 8'($urandom);
      if ($urandom % 4 == 0) tick_once();
      do_cmd(c, 8'($urandom % 6), $urandom, 1'($urandom), 8'($urandom % 12),
             int'($urandom % 4), "random R8");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule